// File: doc/BRIEF.md
# Pattern Table Fetch Unit

This unit carries out the pattern-generation step of a small 4-bit processor core. A start strobe comes with the accumulator, the B register, the carry flag, a 3-bit field from the opcode and the program counter. From these the unit builds a program-memory address and reads one 10-bit word from a synchronous program ROM. That read is the one extra machine cycle the instruction costs.

The two top bits of the fetched word choose where its eight pattern bits go. One choice loads the A/B register pair. The other writes output ports R2 and R3 through the port-write strobes. Both can be chosen at once, and so can neither. The register file and the port unit stay outside this block. The port unit applies its own direction and validity rules to the writes it receives.

Top module: `pgf_fetch_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, rom_rd and all four load/write strobes are low.
- R2: The table address is {op_sel, carry, breg, acc}, with acc in bits 3:0, breg in 7:4, carry in bit 8 and op_sel in 11:9. This value is ORed with the program counter whose six low bits are cleared.
- R3: The address is cut to ADDR_W bits (10 to 12). Address bits at or above ADDR_W are dropped.
- R4: A start accepted in cycle T makes rom_rd high in cycle T+1 only, and done high in cycle T+2 only. The ROM returns data one cycle after rom_rd.
- R5: busy is high in cycles T+1 and T+2 and low in the cycle after done.
- R6: If word bit 8 is set, a_ld and b_ld pulse with done, with a_val equal to word bits 3:0 and b_val equal to word bits 7:4.
- R7: If word bit 9 is set, r2_wr and r3_wr pulse with done, with r2_val equal to word bits 7:4 and r3_val equal to word bits 3:0.
- R8: If word bits 9 and 8 are both set, all four strobes pulse in the same done cycle.
- R9: If word bits 9 and 8 are both clear, done still pulses and no strobe is raised.
- R10: A start that arrives while busy is high is ignored. No further ROM read follows it.
- R11: The operands are captured when a start is accepted. Changing them afterwards does not alter the address of that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pattern fetch |
| op_sel | input | 3 | Low three opcode bits |
| acc | input | 4 | Accumulator contents |
| breg | input | 4 | B register contents |
| carry | input | 1 | Carry flag |
| pc | input | ADDR_W | Program counter |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | ADDR_W | ROM word address |
| rom_data | input | 10 | ROM word, valid one cycle after rom_rd |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| a_ld | output | 1 | Load strobe for A |
| a_val | output | 4 | Value for A |
| b_ld | output | 1 | Load strobe for B |
| b_val | output | 4 | Value for B |
| r2_wr | output | 1 | Write strobe for port R2 |
| r2_val | output | 4 | Value for R2 |
| r3_wr | output | 1 | Write strobe for port R3 |
| r3_val | output | 4 | Value for R3 |

## Verification
The register-pair load and the port write can happen in the same done cycle. That happens when a fetched word has both control bits set. The bench gets this case by choosing a B value whose low bits make the model ROM return control code 3. It then requires all four strobes and all four values in that one cycle, and compares them with the word computed from the expected address. The single-destination and no-destination words are checked the same way, to show that neither path leaks into the other.

// File: rtl/pgf_pkg.sv
// Package: shared constants and types for the pattern table fetch unit.
// Assumes a 10-bit program word: two routing bits above eight pattern bits.
package pgf_pkg;
    localparam int WORD_W   = 10;
    localparam int NIB_W    = 4;
    localparam int PAGE_LSB = 6;   // low program-counter bits replaced by the table index
    localparam int RAW_W    = 12;  // width of the composed table index

    // Fetch sequencer states
    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_FETCH = 2'd1,
        PG_ROUTE = 2'd2
    } pg_state_t;

    // Layout of a fetched word; bit 9 routes to ports, bit 8 to registers
    typedef struct packed {
        logic             to_port;
        logic             to_reg;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } pg_word_t;
endpackage

// File: rtl/pgf_addr.sv
// Module: builds the table address from operands and the program page.
// Assumes ADDR_W lies between 10 and 12; the result is cut to ADDR_W bits.
module pgf_addr
    import pgf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        op_sel,
    input  logic [NIB_W-1:0]  acc,
    input  logic [NIB_W-1:0]  breg,
    input  logic              carry,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr
);
    logic [RAW_W-1:0] pc_ext;
    logic [RAW_W-1:0] index;
    logic [RAW_W-1:0] full;

    // Compose the index, merge the page bits, then cut to the ROM width
    always_comb begin
        pc_ext = '0;
        pc_ext[ADDR_W-1:0] = pc;
        index = {op_sel, carry, breg, acc};
        full  = index | (pc_ext & ~RAW_W'((1 << PAGE_LSB) - 1));
        addr  = full[ADDR_W-1:0];
    end
endmodule

// File: rtl/pgf_seq.sv
// Module: three-state sequencer that accepts a start, issues one ROM read
// and marks the routing cycle. Assumes ROM read latency of one cycle.
module pgf_seq
    import pgf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rom_rd,
    output logic              busy,
    output logic              done
);
    pg_state_t state;

    // Advance the state and capture the address on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PG_IDLE;
            addr_q <= '0;
        end else begin
            case (state)
                PG_IDLE: if (start) begin
                    state  <= PG_FETCH;
                    addr_q <= addr_in;
                end
                PG_FETCH: state <= PG_ROUTE;
                default:  state <= PG_IDLE;
            endcase
        end
    end

    // Decode outputs from the state
    always_comb begin
        rom_rd = (state == PG_FETCH);
        done   = (state == PG_ROUTE);
        busy   = (state != PG_IDLE);
    end

    // R4: every read is caused by a start and is followed by done
    a_r4_read_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> $past(start));
    a_r4_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> done);
    // R10: no new read may follow a busy cycle
    a_r10_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rom_rd);
endmodule

// File: rtl/pgf_route.sv
// Module: decodes the fetched word into register loads and port writes.
// Assumes rom_data is valid during the cycle in which done is high.
module pgf_route
    import pgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] rom_data,
    output logic              a_ld,
    output logic [NIB_W-1:0]  a_val,
    output logic              b_ld,
    output logic [NIB_W-1:0]  b_val,
    output logic              r2_wr,
    output logic [NIB_W-1:0]  r2_val,
    output logic              r3_wr,
    output logic [NIB_W-1:0]  r3_val
);
    pg_word_t w;

    // Split the word and raise the selected strobes
    always_comb begin
        w      = pg_word_t'(rom_data);
        a_ld   = done & w.to_reg;
        b_ld   = done & w.to_reg;
        r2_wr  = done & w.to_port;
        r3_wr  = done & w.to_port;
        a_val  = w.lo;
        b_val  = w.hi;
        r2_val = w.hi;
        r3_val = w.lo;
    end

    // R9: no strobe may appear outside the routing cycle
    a_r9_quiet_outside_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(a_ld || b_ld || r2_wr || r3_wr));
endmodule

// File: rtl/pgf_fetch_unit.sv
// Module: top of the pattern table fetch unit. It joins address build,
// sequencing and routing. Assumes a synchronous ROM with one cycle of latency.
module pgf_fetch_unit
    import pgf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [3:0]        acc,
    input  logic [3:0]        breg,
    input  logic              carry,
    input  logic [ADDR_W-1:0] pc,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [9:0]        rom_data,
    output logic              busy,
    output logic              done,
    output logic              a_ld,
    output logic [3:0]        a_val,
    output logic              b_ld,
    output logic [3:0]        b_val,
    output logic              r2_wr,
    output logic [3:0]        r2_val,
    output logic              r3_wr,
    output logic [3:0]        r3_val
);
    logic [ADDR_W-1:0] addr_c;

    pgf_addr #(.ADDR_W(ADDR_W)) u_addr (
        .op_sel (op_sel),
        .acc    (acc),
        .breg   (breg),
        .carry  (carry),
        .pc     (pc),
        .addr   (addr_c)
    );

    pgf_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .addr_in (addr_c),
        .addr_q  (rom_addr),
        .rom_rd  (rom_rd),
        .busy    (busy),
        .done    (done)
    );

    pgf_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .rom_data (rom_data),
        .a_ld     (a_ld),
        .a_val    (a_val),
        .b_ld     (b_ld),
        .b_val    (b_val),
        .r2_wr    (r2_wr),
        .r2_val   (r2_val),
        .r3_wr    (r3_wr),
        .r3_val   (r3_val)
    );

    // R5: done only arrives while busy
    a_r5_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R11: the address does not move between the read and the routing cycle
    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(rom_addr));
endmodule

// File: tb/tb_pgf_fetch_unit.sv
// Directed bench for the pattern table fetch unit.
module tb_pgf_fetch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [3:0]  acc = '0, breg = '0;
    logic        carry = 1'b0;
    logic [11:0] pc = '0;
    logic        rom_rd, busy, done, a_ld, b_ld, r2_wr, r3_wr;
    logic [11:0] rom_addr;
    logic [9:0]  rom_q = '0;
    logic [3:0]  a_val, b_val, r2_val, r3_val;
    logic        rd10, busy10, done10, a10, b10, w2_10, w3_10;
    logic [9:0]  addr10;
    logic [9:0]  rom_q10 = '0;
    logic [3:0]  av10, bv10, v2_10, v3_10;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    pgf_fetch_unit #(.ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .acc(acc),
        .breg(breg), .carry(carry), .pc(pc), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .rom_data(rom_q), .busy(busy), .done(done), .a_ld(a_ld), .a_val(a_val),
        .b_ld(b_ld), .b_val(b_val), .r2_wr(r2_wr), .r2_val(r2_val),
        .r3_wr(r3_wr), .r3_val(r3_val));

    pgf_fetch_unit #(.ADDR_W(10)) dut10 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .acc(acc),
        .breg(breg), .carry(carry), .pc(pc[9:0]), .rom_rd(rd10), .rom_addr(addr10),
        .rom_data(rom_q10), .busy(busy10), .done(done10), .a_ld(a10), .a_val(av10),
        .b_ld(b10), .b_val(bv10), .r2_wr(w2_10), .r2_val(v2_10),
        .r3_wr(w3_10), .r3_val(v3_10));

    // Model ROM contents: routing code = address bits 5:4, pattern is a hash
    function automatic logic [9:0] rom_fn(input logic [11:0] a);
        logic [7:0] p;
        p = a[7:0] * 8'd29 + 8'd71 + {4'd0, a[11:8]};
        return {a[5:4], p};
    endfunction

    always @(posedge clk) begin
        if (rom_rd) rom_q <= rom_fn(rom_addr);
        if (rd10)   rom_q10 <= rom_fn({2'b00, addr10});
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_addr(input logic [2:0] o, input logic c,
        input logic [3:0] b, input logic [3:0] a, input logic [11:0] p);
        return {o, c, b, a} | (p & 12'hFC0);
    endfunction

    // One fetch with full timing and routing checks
    task automatic run_op(input logic [2:0] o, input logic c, input logic [3:0] b,
                          input logic [3:0] a, input logic [11:0] p);
        logic [11:0] ea;
        logic [9:0]  w;
        ea = exp_addr(o, c, b, a, p);
        w  = rom_fn(ea);
        @(negedge clk);
        op_sel = o; carry = c; breg = b; acc = a; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        acc = ~a; breg = ~b; op_sel = ~o;   // R11: later changes must not matter
        chk("R4 rd in T+1", rom_rd, 1);
        chk("R5 busy T+1", busy, 1);
        chk("R2/R11 address", rom_addr, ea);
        chk("R4 no done T+1", done, 0);
        @(negedge clk);
        chk("R4 done T+2", done, 1);
        chk("R4 rd low T+2", rom_rd, 0);
        chk("R5 busy T+2", busy, 1);
        chk("R6 a_ld", a_ld, w[8]);
        chk("R6 b_ld", b_ld, w[8]);
        chk("R7 r2_wr", r2_wr, w[9]);
        chk("R7 r3_wr", r3_wr, w[9]);
        if (w[8]) begin
            chk("R6 a_val", a_val, w[3:0]);
            chk("R6 b_val", b_val, w[7:4]);
        end
        if (w[9]) begin
            chk("R7 r2_val", r2_val, w[7:4]);
            chk("R7 r3_val", r3_val, w[3:0]);
        end
        @(negedge clk);
        chk("R5 busy low after", busy, 0);
        chk("R4 done single", done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 rd", rom_rd, 0);
        chk("R1 strobes", {a_ld, b_ld, r2_wr, r3_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {busy, done, rom_rd, a_ld, r2_wr}, 0);
    endtask

    task automatic t_routes();
        run_op(3'd2, 1'b0, 4'h1, 4'h5, 12'h0AB);  // code 1: registers, R6
        run_op(3'd5, 1'b1, 4'h2, 4'hC, 12'h3FF);  // code 2: ports, R7
        run_op(3'd7, 1'b1, 4'h3, 4'h9, 12'h000);  // code 3: both, R8
        run_op(3'd0, 1'b0, 4'h0, 4'h0, 12'hFC1);  // code 0: none, R9
        run_op(3'd1, 1'b0, 4'hC, 4'hF, 12'h840);  // R2 page merge
    endtask

    // R8: explicit check that all four strobes share one cycle
    task automatic t_both();
        logic [11:0] ea;
        ea = exp_addr(3'd4, 1'b0, 4'h7, 4'h2, 12'h100);
        @(negedge clk);
        op_sel = 3'd4; carry = 1'b0; breg = 4'h7; acc = 4'h2; pc = 12'h100; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R8 all strobes", {a_ld, b_ld, r2_wr, r3_wr}, 4'hF);
        chk("R8 values", {a_val, b_val, r2_val, r3_val},
            {rom_fn(ea)[3:0], rom_fn(ea)[7:4], rom_fn(ea)[7:4], rom_fn(ea)[3:0]});
        @(negedge clk);
    endtask

    // R3: the 10-bit instance drops address bits 11:10
    task automatic t_mask();
        @(negedge clk);
        op_sel = 3'd6; carry = 1'b1; breg = 4'hA; acc = 4'h3; pc = 12'hE55; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 masked addr", addr10, exp_addr(3'd6, 1'b1, 4'hA, 4'h3, 12'hE55) & 12'h3FF);
        chk("R3 wide addr", rom_addr, exp_addr(3'd6, 1'b1, 4'hA, 4'h3, 12'hE55));
        repeat (2) @(negedge clk);
    endtask

    // R10: starts during busy produce no new read
    task automatic t_busy_ignore();
        @(negedge clk);
        op_sel = 3'd3; carry = 1'b0; breg = 4'h1; acc = 4'h4; pc = 12'h200; start = 1'b1;
        @(negedge clk);                 // T+1, start still high while busy
        chk("R10 first read", rom_rd, 1);
        @(negedge clk);                 // T+2
        chk("R10 no read T+2", rom_rd, 0);
        start = 1'b0;
        @(negedge clk);
        chk("R10 no read after", rom_rd, 0);
        chk("R10 idle after", busy, 0);
    endtask

    initial begin
        t_reset();
        t_routes();
        t_both();
        t_mask();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule